// File: doc/BRIEF.md
# Four-Lane Synchronized Ping-Pong Frame Buffer

This block collects stereo sample words from four independent input lanes into per-lane double-buffered storage. Each lane owns two halves. A lane fills one half with a fixed number of stereo frames and then moves straight on to its other half. Every lane that finishes a half raises its own bit in a completion mask.

When the last outstanding lane completes, the whole half is released at once. The block emits a one-cycle ready pulse and flips its bank indicator. It then streams the finished half out as one interleaved 8-channel sequence for a time-division transmitter, while the lanes keep writing the opposite half. The lanes may drift against each other by up to a half, and readout still waits for all of them. A lane that laps back into a half that is still being read is recorded in a sticky overrun flag.

Top module: `lane_pingpong`

## Requirements
- R1: After reset, out_valid, half_ready, bank and overrun are all 0.
- R2: A lane accepts one word per cycle in which its valid bit is high. The first word of a frame is the left sample and the second is the right. After 2*FRAMES words the lane continues into its other half with no idle cycle.
- R3: No half_ready pulse occurs while any lane has not yet completed its current half.
- R4: When the last of the four lanes accepts the final word of its half, half_ready is high in the following cycle for exactly one cycle. In that same cycle, bank shows the inverted value.
- R5: out_valid rises in the cycle after half_ready. It then stays high for exactly 8*FRAMES consecutive cycles and then falls.
- R6: Readout order is frame-major. For frame f = 0 .. FRAMES-1 it emits lane 0 left, lane 0 right, lane 1 left, lane 1 right, lane 2 left, lane 2 right, lane 3 left, lane 3 right.
- R7: Readout delivers the half that was just completed, which is the half the bank indicator named before it toggled. It contains no words from the other half.
- R8: overrun sets if a lane writes a frame into the half being read, or if all lanes complete while a readout is still running. Otherwise it stays 0. Once set, it holds until reset.
- R9: The completion mask clears when readout starts. A lane completing its next half on its own does not release that half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | LANES | Per-lane word strobe |
| lane_data | input | LANES*DW | Lane words packed, lane l at bits [l*DW +: DW] |
| out_valid | output | 1 | Readout word valid |
| out_data | output | DW | Readout word |
| half_ready | output | 1 | One-cycle pulse when a half is released |
| bank | output | 1 | Half currently being filled by the lanes |
| overrun | output | 1 | Sticky lap-over flag |

## Verification
The bench builds the block with FRAMES set to 4 and the default four lanes of 32-bit words, so a half is eight words per lane and a full readout is 32 words. That brings several things within a few hundred cycles: skewed lane completion, release of both halves in turn with their full interleaved contents, and the mask clearing between releases. It also reaches a lane lapping both halves during an active readout, which exercises the overrun path and its stickiness.

// File: rtl/lane_pingpong.sv
module lane_pingpong #(
  parameter int LANES  = 4,
  parameter int FRAMES = 480,
  parameter int DW     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      lane_valid,
  input  logic [LANES*DW-1:0]   lane_data,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data,
  output logic                  half_ready,
  output logic                  bank,
  output logic                  overrun
);
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int AW = $clog2(2 * FRAMES);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  function automatic logic [AW-1:0] slot(input logic h, input logic [FW-1:0] i);
    return h ? AW'(FRAMES) + AW'(i) : AW'(i);
  endfunction

  logic [2*DW-1:0] mem [LANES][2*FRAMES];
  logic [DW-1:0]   left_q [LANES];
  logic [FW-1:0]   wr_idx [LANES];
  logic [LANES-1:0] wr_half, wr_odd, mask, done, hit, mask_nxt;
  logic            all_done;

  logic            rd_busy, rd_half, rd_w, rd_last;
  logic [FW-1:0]   rd_f;
  logic [LW-1:0]   rd_l;
  logic [2*DW-1:0] rd_entry;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      done[l] = lane_valid[l] & wr_odd[l] & (wr_idx[l] == FW'(FRAMES - 1));
      hit[l]  = lane_valid[l] & wr_odd[l] & rd_busy & (wr_half[l] == rd_half);
    end
  end

  assign mask_nxt = mask | done;
  assign all_done = &mask_nxt;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n) begin
        wr_half[l] <= 1'b0;
        wr_odd[l]  <= 1'b0;
        wr_idx[l]  <= '0;
        left_q[l]  <= '0;
      end else if (lane_valid[l]) begin
        if (!wr_odd[l]) begin
          left_q[l] <= lane_data[l*DW +: DW];
          wr_odd[l] <= 1'b1;
        end else begin
          mem[l][slot(wr_half[l], wr_idx[l])] <= {left_q[l], lane_data[l*DW +: DW]};
          wr_odd[l] <= 1'b0;
          if (done[l]) begin
            wr_idx[l]  <= '0;
            wr_half[l] <= ~wr_half[l];
          end else begin
            wr_idx[l] <= wr_idx[l] + 1'b1;
          end
        end
      end
    end
  end

  assign rd_entry = mem[rd_l][slot(rd_half, rd_f)];
  assign rd_last  = rd_w & (rd_l == LW'(LANES - 1)) & (rd_f == FW'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask       <= '0;
      bank       <= 1'b0;
      half_ready <= 1'b0;
      overrun    <= 1'b0;
      rd_busy    <= 1'b0;
      rd_half    <= 1'b0;
      rd_w       <= 1'b0;
      rd_l       <= '0;
      rd_f       <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      half_ready <= all_done;
      if (|hit || (all_done && rd_busy)) overrun <= 1'b1;
      out_valid <= rd_busy;
      if (rd_busy) begin
        out_data <= rd_w ? rd_entry[DW-1:0] : rd_entry[2*DW-1:DW];
        rd_w <= ~rd_w;
        if (rd_w) begin
          if (rd_l == LW'(LANES - 1)) begin
            rd_l <= '0;
            rd_f <= rd_f + 1'b1;
          end else begin
            rd_l <= rd_l + 1'b1;
          end
        end
        if (rd_last) rd_busy <= 1'b0;
      end
      if (all_done) begin
        mask    <= '0;
        bank    <= ~bank;
        rd_half <= bank;
        rd_busy <= 1'b1;
        rd_w    <= 1'b0;
        rd_l    <= '0;
        rd_f    <= '0;
      end else begin
        mask <= mask_nxt;
      end
    end
  end

  // R4
  half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_ready |=> !half_ready);

  // R4
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_ready) |-> (bank != $past(bank)));

  // R5
  stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(half_ready));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R3
  release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && done == '0) |=> !half_ready);
endmodule

// File: tb/lane_pingpong_tb.sv
module lane_pingpong_tb_top;
  localparam int FR = 4;
  localparam int HW = 2 * FR;
  localparam int RW = 8 * FR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lane_valid = '0;
  logic [127:0] lane_data = '0;
  logic        out_valid, half_ready, bank, overrun;
  logic [31:0] out_data;

  int total = 0;
  int fails = 0;
  int cnt [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  lane_pingpong #(.LANES(4), .FRAMES(FR), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
    .out_valid(out_valid), .out_data(out_data), .half_ready(half_ready),
    .bank(bank), .overrun(overrun));

  // {lane mask, expected half_ready, expected bank}
  localparam logic [5:0] STEPS [16] = '{
    6'b0111_0_0, 6'b0111_0_0, 6'b0111_0_0, 6'b0111_0_0,
    6'b0111_0_0, 6'b0111_0_0, 6'b0111_0_0, 6'b0111_0_0,
    6'b1000_0_0, 6'b1000_0_0, 6'b1000_0_0, 6'b1000_0_0,
    6'b1000_0_0, 6'b1000_0_0, 6'b1000_0_0, 6'b1000_1_1};

  function automatic logic [31:0] pat(input int p, input int l, input int f, input int w);
    return 32'((p << 12) | (l << 8) | (f << 1) | w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] m);
    for (int l = 0; l < 4; l++) begin
      if (m[l]) begin
        lane_data[l*32 +: 32] = pat(cnt[l] / HW, l, (cnt[l] % HW) / 2, cnt[l] % 2);
        cnt[l]++;
      end
    end
    lane_valid = m;
    @(negedge clk);
    lane_valid = '0;
  endtask

  // R5 R6 R7: called at the negedge where half_ready was seen high
  task automatic read_half(input int p);
    @(negedge clk);
    chk("R4 pulse width", {31'b0, half_ready}, 32'd0);
    chk("R5 start", {31'b0, out_valid}, 32'd1);
    for (int i = 0; i < RW; i++) begin
      chk("R6 R7 word", out_data, pat(p, (i / 2) % 4, i / 8, i % 2));
      chk("R5 valid run", {31'b0, out_valid}, 32'd1);
      @(negedge clk);
    end
    chk("R5 end", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 half_ready", {31'b0, half_ready}, 32'd0);
    chk("R1 bank", {31'b0, bank}, 32'd0);
    chk("R1 overrun", {31'b0, overrun}, 32'd0);

    // R2 R3 R4: skewed lanes, release only when lane 3 finishes
    for (int k = 0; k < 16; k++) begin
      push(STEPS[k][5:2]);
      chk(STEPS[k][1] ? "R4 release" : "R3 hold", {31'b0, half_ready}, {31'b0, STEPS[k][1]});
      chk("R4 bank", {31'b0, bank}, {31'b0, STEPS[k][0]});
    end
    read_half(0);

    // R9: lane 0 alone completes half 1, mask was cleared
    for (int k = 0; k < HW; k++) begin
      push(4'b0001);
      chk("R9 no release", {31'b0, half_ready}, 32'd0);
    end
    for (int k = 0; k < HW; k++) begin
      push(4'b1110);
      chk(k == HW - 1 ? "R4 second release" : "R3 hold", {31'b0, half_ready},
          (k == HW - 1) ? 32'd1 : 32'd0);
    end
    chk("R4 bank back", {31'b0, bank}, 32'd0);
    read_half(1);
    chk("R8 clean", {31'b0, overrun}, 32'd0);

    // R8: lanes lap both halves during a readout
    for (int k = 0; k < HW; k++) push(4'b1111);
    chk("R4 third release", {31'b0, half_ready}, 32'd1);
    for (int k = 0; k < HW - 1; k++) push(4'b1111);
    chk("R8 other half ok", {31'b0, overrun}, 32'd0);
    push(4'b1111);
    chk("R8 set", {31'b0, overrun}, 32'd1);
    repeat (100) @(negedge clk);
    chk("R8 sticky", {31'b0, overrun}, 32'd1);
    chk("R5 idle", {31'b0, out_valid}, 32'd0);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 overrun cleared", {31'b0, overrun}, 32'd0);
    chk("R1 bank cleared", {31'b0, bank}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule